// File: doc/BRIEF.md
# Per-Rank DRAM Thermal Throttle Controller

This block sits beside a memory channel's command scheduler and decides, for each of four DRAM ranks, whether new commands to that rank must be held back for thermal reasons. Every rank supplies a wide virtual-temperature accumulator. In closed-loop mode the block compares a fixed 8-bit high slice of that accumulator against a programmable per-rank limit. In direct mode a software-written vector forces the throttle decision. A mode selector chooses between the two, or turns throttling off.

Each time a rank's throttle drops, that rank gets a guaranteed run window. It runs unthrottled for a programmable number of DCLKs before throttle may return, so a rank hovering near its limit still makes progress. The block also raises a double-rate refresh request. In closed-loop mode it does so while any rank is throttled. In direct mode it follows a software bit. All outputs are registered one cycle behind their inputs.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high) drives `throttleMask` and `refreshDouble` to 0 on the next edge. It also clears every run-window counter, so throttle may assert on the first edge after reset.
- R2: With `modeSel` = 1 (closed loop), bit i of `throttleMask` is 1 one cycle after `virtTemp` bits [36:29] of rank i (bit i*37+36 down to i*37+29 of the flat input) are greater than or equal to that rank's limit. Bits [28:0] of each rank's temperature have no effect.
- R3: Rank i's 8-bit limit is `rankLimits[8*i+7:8*i]`: rank 0 in [7:0], rank 1 in [15:8], rank 2 in [23:16], rank 3 in [31:24].
- R4: With a limit of 255, a rank throttles only when its slice equals 255. A slice of 254 leaves it unthrottled.
- R5: With a limit of 0, a rank in closed-loop mode is throttled whenever its run window is not open, whatever its temperature.
- R6: When a rank's throttle falls, it stays low for max(N,1) cycles, where N is `minRunCycles`. If demand is present throughout, it reasserts on the edge after those cycles. A rise in demand during the window is ignored.
- R7: With `modeSel` = 2 (direct), bit i of `throttleMask` follows `forceVec[i]` one cycle later, subject to R6. Temperatures and limits have no effect.
- R8: In closed-loop mode, `refreshDouble` is 1 exactly when at least one bit of `throttleMask` is 1.
- R9: In direct mode, `refreshDouble` follows `forceRefresh` one cycle later, independent of the mask.
- R10: With `modeSel` = 0 or 3, both outputs are 0 one cycle later. `forceVec`, `forceRefresh` and temperatures are ignored.
- R11: Each rank's run window is independent. A window open on one rank does not change the mask bit of any other rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DCLK |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 2 | 0/3 off, 1 closed loop, 2 direct |
| virtTemp | input | 148 | Four 37-bit virtual temperatures, rank 0 in the low bits |
| rankLimits | input | 32 | Four packed 8-bit throttle limits |
| minRunCycles | input | 10 | Minimum unthrottled DCLKs after a throttle episode |
| forceVec | input | 4 | Direct-mode per-rank throttle vector |
| forceRefresh | input | 1 | Direct-mode double-refresh request |
| throttleMask | output | 4 | Per-rank throttle, bit i for rank i |
| refreshDouble | output | 1 | Double-rate refresh request |

## Verification
The closed-loop compare is driven with several kinds of slice value:
- slices just below, equal to and above each rank's distinct limit, which separates `>=` from `>` and catches swapped limit bytes;
- all-ones low bits under a below-limit slice, which exposes a comparison that reaches below bit 29;
- the 254 and 255 slices against a 255 limit, and any temperature against a 0 limit, which probe the two ends of the range.

The run window is exercised in three ways:
- demand drops for one cycle and then returns, at N = 3, N = 1, N = 0 and the reset value 64, which measures the exact length of the gap;
- another rank toggles at the same time, which shows the windows are independent;
- direct and off modes are driven with hot temperatures, so that any leak of the temperature path into those modes shows up.

// File: rtl/thr_pkg.sv
package thr_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_CLOSED  = 2'd1,
    MODE_DIRECT  = 2'd2,
    MODE_OFF_ALT = 2'd3
  } thrMode_e;

  // Strobes decoded by the control half and consumed by every rank lane.
  typedef struct packed {
    logic closedEn;
    logic directEn;
  } thrStrobes_t;

endpackage

// File: rtl/thr_mode_ctrl.sv
module thr_mode_ctrl
  import thr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  modeSel,
  input  logic        forceRefresh,
  input  logic        anyThrottleNext,
  output thrStrobes_t strobes,
  output logic        refreshDouble
);

  thrMode_e modeNow;

  always_comb begin
    modeNow          = thrMode_e'(modeSel);
    strobes.closedEn = (modeNow == MODE_CLOSED);
    strobes.directEn = (modeNow == MODE_DIRECT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refreshDouble <= 1'b0;
    end else if (strobes.closedEn) begin
      refreshDouble <= anyThrottleNext;
    end else if (strobes.directEn) begin
      refreshDouble <= forceRefresh;
    end else begin
      refreshDouble <= 1'b0;
    end
  end

  // R10: an off mode leaves no refresh request behind
  p_off_refresh_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(strobes.closedEn) && !$past(strobes.directEn)) |-> !refreshDouble);

  // R9: direct mode copies the software bit
  p_direct_refresh_r9: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.directEn) |-> (refreshDouble == $past(forceRefresh)));

endmodule

// File: rtl/thr_rank_lane.sv
module thr_rank_lane
  import thr_pkg::*;
#(
  parameter int TEMP_W   = 37,
  parameter int SLICE_HI = 36,
  parameter int SLICE_LO = 29,
  parameter int DUTY_W   = 10,
  localparam int SLICE_W = SLICE_HI - SLICE_LO + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  thrStrobes_t       strobes,
  input  logic [TEMP_W-1:0] temp,
  input  logic [SLICE_W-1:0] limit,
  input  logic              forceBit,
  input  logic [DUTY_W-1:0] minRun,
  output logic              throttleNext,
  output logic              throttleQ
);

  logic [SLICE_W-1:0] tempSlice;
  logic               hot;
  logic               demand;
  logic [DUTY_W-1:0]  holdCnt;
  logic [DUTY_W-1:0]  loadVal;
  logic               unusedTempBits;

  assign tempSlice = temp[SLICE_HI:SLICE_LO];

  generate
    if (TEMP_W - 1 > SLICE_HI) begin : g_hiSpare
      assign unusedTempBits = ^{temp[TEMP_W-1:SLICE_HI+1], temp[SLICE_LO-1:0]};
    end else begin : g_noHiSpare
      assign unusedTempBits = ^temp[SLICE_LO-1:0];
    end
  endgenerate

  always_comb begin
    hot          = (tempSlice >= limit);
    demand       = (strobes.closedEn && hot) || (strobes.directEn && forceBit);
    throttleNext = demand && (holdCnt == '0);
    loadVal      = (minRun == '0) ? '0 : (minRun - DUTY_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      throttleQ <= 1'b0;
      holdCnt   <= '0;
    end else begin
      throttleQ <= throttleNext;
      if (throttleQ && !throttleNext) begin
        holdCnt <= loadVal;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - DUTY_W'(1);
      end
    end
  end

  // R6: a rising throttle only follows an exhausted run window
  p_window_closed_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(throttleQ) |-> ($past(holdCnt) == '0));

  // R2: closed-loop throttle needs the slice at or above the limit
  p_closed_hot_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(strobes.closedEn) && throttleQ) |-> $past(hot));

  // R7: direct throttle needs the software bit
  p_direct_force_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(strobes.directEn) && throttleQ) |-> $past(forceBit));

endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import thr_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int TEMP_W    = 37,
  parameter int SLICE_HI  = 36,
  parameter int SLICE_LO  = 29,
  parameter int DUTY_W    = 10,
  localparam int LIM_W    = SLICE_HI - SLICE_LO + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  modeSel,
  input  logic [NUM_RANKS*TEMP_W-1:0] virtTemp,
  input  logic [NUM_RANKS*LIM_W-1:0]  rankLimits,
  input  logic [DUTY_W-1:0]           minRunCycles,
  input  logic [NUM_RANKS-1:0]        forceVec,
  input  logic                        forceRefresh,
  output logic [NUM_RANKS-1:0]        throttleMask,
  output logic                        refreshDouble
);

  thrStrobes_t          strobes;
  logic [NUM_RANKS-1:0] throttleNextVec;

  thr_mode_ctrl u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .modeSel         (modeSel),
    .forceRefresh    (forceRefresh),
    .anyThrottleNext (|throttleNextVec),
    .strobes         (strobes),
    .refreshDouble   (refreshDouble)
  );

  generate
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_lane
      thr_rank_lane #(
        .TEMP_W   (TEMP_W),
        .SLICE_HI (SLICE_HI),
        .SLICE_LO (SLICE_LO),
        .DUTY_W   (DUTY_W)
      ) u_lane (
        .clk          (clk),
        .rst          (rst),
        .strobes      (strobes),
        .temp         (virtTemp[r*TEMP_W +: TEMP_W]),
        .limit        (rankLimits[r*LIM_W +: LIM_W]),
        .forceBit     (forceVec[r]),
        .minRun       (minRunCycles),
        .throttleNext (throttleNextVec[r]),
        .throttleQ    (throttleMask[r])
      );
    end
  endgenerate

  // R8: closed-loop refresh request mirrors the throttled set
  p_refresh_tracks_r8: assert property (@(posedge clk) disable iff (rst)
    $past(modeSel == 2'd1) |-> (refreshDouble == (|throttleMask)));

  // R10: off modes clear every mask bit
  p_off_mask_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(modeSel) == 2'd0 || $past(modeSel) == 2'd3) |-> (throttleMask == '0));

  // R1: the edge after a reset cycle leaves both outputs low
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (throttleMask == '0 && !refreshDouble));

endmodule

// File: tb/thermal_throttle_ctrl_tb.sv
module thermal_throttle_ctrl_tb;

  localparam int NR = 4;
  localparam int TW = 37;

  logic            clk = 1'b0;
  logic            rst;
  logic [1:0]      modeSel;
  logic [NR*TW-1:0] virtTemp;
  logic [31:0]     rankLimits;
  logic [9:0]      minRunCycles;
  logic [NR-1:0]   forceVec;
  logic            forceRefresh;
  logic [NR-1:0]   throttleMask;
  logic            refreshDouble;

  always #4 clk = ~clk;

  thermal_throttle_ctrl u_dut (
    .clk           (clk),
    .rst           (rst),
    .modeSel       (modeSel),
    .virtTemp      (virtTemp),
    .rankLimits    (rankLimits),
    .minRunCycles  (minRunCycles),
    .forceVec      (forceVec),
    .forceRefresh  (forceRefresh),
    .throttleMask  (throttleMask),
    .refreshDouble (refreshDouble)
  );

  typedef struct {
    logic [NR-1:0] mask;
    logic          refr;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state built from the requirements
  logic [NR-1:0] mdlThr = '0;
  int            mdlCnt [NR] = '{default: 0};
  logic          mdlRef = 1'b0;

  function automatic logic [TW-1:0] mkTemp(input logic [7:0] slice, input logic [28:0] low);
    return {slice, low};
  endfunction

  task automatic setSlice(input int r, input logic [7:0] s, input logic [28:0] low = 29'h0ABC_DEF);
    virtTemp[r*TW +: TW] = mkTemp(s, low);
  endtask

  // Driver: model the next outputs from the present inputs, queue them, advance a cycle.
  task automatic step(input string tag);
    expItem_t it;
    if (rst) begin
      mdlThr = '0;
      mdlRef = 1'b0;
      for (int i = 0; i < NR; i++) mdlCnt[i] = 0;
    end else begin
      for (int i = 0; i < NR; i++) begin
        logic dem;
        logic nt;
        dem = (modeSel == 2'd1) ? (virtTemp[i*TW+29 +: 8] >= rankLimits[i*8 +: 8]) :
              (modeSel == 2'd2) ? forceVec[i] : 1'b0;
        nt  = dem && (mdlCnt[i] == 0);
        if (mdlThr[i] && !nt) mdlCnt[i] = (minRunCycles == 0) ? 0 : int'(minRunCycles) - 1;
        else if (mdlCnt[i] != 0) mdlCnt[i]--;
        mdlThr[i] = nt;
      end
      mdlRef = (modeSel == 2'd1) ? (|mdlThr) : (modeSel == 2'd2) ? forceRefresh : 1'b0;
    end
    it.mask = mdlThr;
    it.refr = mdlRef;
    it.tag  = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic stepN(input int n, input string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  // Monitor: compare one queued item per cycle, after the edge settles.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() != 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (throttleMask !== e.mask || refreshDouble !== e.refr) begin
          errors++;
          $display("FAIL %s: mask=%b refresh=%b expected mask=%b refresh=%b",
                   e.tag, throttleMask, refreshDouble, e.mask, e.refr);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    modeSel = 2'd1;
    rankLimits = {8'hC0, 8'h80, 8'h40, 8'h10};
    minRunCycles = 10'd64;
    forceVec = 4'hF;
    forceRefresh = 1'b1;
    for (int r = 0; r < NR; r++) setSlice(r, 8'hFF);
    stepN(3, "R1 reset with hot inputs");

    rst = 1'b0;
    minRunCycles = 10'd2;
    for (int r = 0; r < NR; r++) setSlice(r, 8'h00);
    step("R1 idle after reset");

    // R2/R3: each rank against its own limit, equal and just-below
    setSlice(1, 8'h40);
    stepN(2, "R2 R3 R8 rank1 at limit");
    setSlice(1, 8'h3F, 29'h1FFF_FFFF);
    step("R2 low bits ignored below limit");
    setSlice(0, 8'h10); setSlice(2, 8'h7F); setSlice(3, 8'hC1);
    stepN(2, "R3 R8 distinct limits per rank");
    setSlice(2, 8'h80);
    step("R3 rank2 reaches limit");
    for (int r = 0; r < NR; r++) setSlice(r, 8'h00);
    stepN(4, "R8 all cool refresh drops");

    // R4: limit 255
    rankLimits = {8'hC0, 8'hFF, 8'h40, 8'h10};
    setSlice(2, 8'hFE);
    stepN(2, "R4 slice 254 under limit 255");
    setSlice(2, 8'hFF);
    stepN(2, "R4 slice 255 at limit 255");
    setSlice(2, 8'h00);
    stepN(3, "R4 release");

    // R5: limit 0
    rankLimits = {8'hC0, 8'hFF, 8'h40, 8'h00};
    stepN(3, "R5 limit zero throttles cold rank");
    rankLimits = {8'hC0, 8'hFF, 8'h40, 8'h10};
    stepN(3, "R5 release");

    // R6/R11: window of 3 on rank1 while rank3 toggles
    minRunCycles = 10'd3;
    setSlice(1, 8'h50); setSlice(3, 8'hD0);
    stepN(2, "R6 R11 both throttled");
    setSlice(1, 8'h00);
    step("R6 rank1 demand drops");
    setSlice(1, 8'h50); setSlice(3, 8'h00);
    step("R6 R11 rank1 in window rank3 drops");
    setSlice(3, 8'hD0);
    stepN(6, "R6 R11 window timing");
    minRunCycles = 10'd1;
    setSlice(1, 8'h00); step("R6 N=1 drop");
    setSlice(1, 8'h50); stepN(3, "R6 N=1 return");
    minRunCycles = 10'd0;
    setSlice(1, 8'h00); step("R6 N=0 drop");
    setSlice(1, 8'h50); stepN(3, "R6 N=0 return");
    minRunCycles = 10'd64;
    setSlice(1, 8'h00); step("R6 N=64 drop");
    setSlice(1, 8'h50); stepN(68, "R6 N=64 window");
    for (int r = 0; r < NR; r++) setSlice(r, 8'h00);
    minRunCycles = 10'd2;
    stepN(70, "R6 drain");

    // R7/R9: direct mode with hot temperatures
    modeSel = 2'd2;
    for (int r = 0; r < NR; r++) setSlice(r, 8'hFF);
    forceVec = 4'b0000; forceRefresh = 1'b1;
    stepN(2, "R7 R9 hot temps ignored refresh alone");
    forceVec = 4'b1010; forceRefresh = 1'b0;
    stepN(2, "R7 R9 vector 1010");
    forceVec = 4'b0101;
    stepN(5, "R7 R6 vector swap");
    forceVec = 4'b1111; forceRefresh = 1'b1;
    stepN(4, "R7 R9 all forced");

    // R10: off modes
    modeSel = 2'd0;
    stepN(3, "R10 mode 0");
    modeSel = 2'd3;
    stepN(3, "R10 mode 3");
    modeSel = 2'd1;
    stepN(4, "R10 back to closed loop");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule